// File: doc/BRIEF.md
# Memory Needle Scan Engine

This block walks a byte-addressed memory upward from a start pointer and compares it against a needle of one to four bytes. It has two modes. In scan mode it slides forward one byte at a time and stops at the first address where the whole needle appears. In skip mode it steps forward by the needle width and stops at the first element that differs from the needle. Skip mode is the usual way to pass over runs of spaces. Scan mode can find a terminating zero, and subtracting the start pointer from the returned pointer then gives the string length.

An operation starts with a one-cycle `start` pulse. The engine then issues one read per cycle on a single-byte read port whose data returns one cycle later. It ends with a one-cycle `done` pulse, a `found` flag and a 24-bit result pointer. A length limit bounds the walk, so a missing stop condition ends the operation with `found` low. Instruction decode, register file access and fetch are handled outside the block.

Top module: `scan_engine`

## Requirements
- R1: During and after reset, `done`, `found` and `rd_en` are 0 and `result_ptr` is 0.
- R2: In scan mode (`mode`=0) with a one-byte needle (`needle_sel`=0, byte `needle[7:0]`), the result is the lowest address at or above `start_ptr` that holds the needle byte, and `found` is 1.
- R3: `needle_sel`=k selects a needle of k+1 bytes, taken from `needle[8k+7:0]`. The bytes are compared little-endian: `needle[7:0]` is matched at the lowest address. A scan match requires every selected byte to be equal, so a partial match or a byte-reversed match does not stop the scan.
- R4: In skip mode (`mode`=1) the engine compares consecutive elements of W=k+1 bytes, at offsets 0, W, 2W and so on. It returns the address of the first element that differs from the needle, with `found`=1.
- R5: `max_len` bounds the operation. Scan mode tests candidate offsets 0 to `max_len`-1; if none matches, `found`=0 and the result is `start_ptr`+`max_len`. Skip mode tests element offsets below `max_len`; if all of them match, `found`=0 and the result is `start_ptr` plus the first multiple of W that is not below `max_len`. When `max_len`=0, the result is `start_ptr` with `found`=0.
- R6: A stop condition at the last allowed offset takes priority over the limit, and reports `found`=1 at that offset.
- R7: Pointers are 24 bits, made of an 8-bit bank and a 16-bit address. Incrementing carries from the address into the bank. For a zero-byte scan, `result_ptr`-`start_ptr` equals the string length.
- R8: Reads start at `start_ptr` in the cycle after `start` and continue at consecutive addresses, one per cycle. `rd_data` is taken one cycle after the cycle in which `rd_en` is high.
- R9: `done` is high for exactly one cycle. `found` and `result_ptr` change only with `done` and hold until the next `done`. A `start` that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 1 | 0 = scan for the needle, 1 = skip over the needle |
| start_ptr | input | 24 | Starting address, bank in bits 23:16 |
| needle | input | 32 | Needle bytes, lowest address in bits 7:0 |
| needle_sel | input | 2 | Needle width minus one, in bytes |
| max_len | input | 16 | Byte bound of the operation |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Stop condition met before the limit |
| result_ptr | output | 24 | Pointer at which the operation ended |
| rd_en | output | 1 | Read request |
| rd_addr | output | 24 | Read address |
| rd_data | input | 8 | Read data, valid one cycle after the request |

## Verification
The stop decision and the limit expiry can fall in the same cycle. This happens when the needle, or a mismatching element, sits exactly at the last offset that `max_len` allows. The bench provokes this by placing a needle byte at offset five. It runs the scan once with a bound of five and once with a bound of six. The first run must end with `found` low at `start_ptr`+5. The second run sees the match and the expiry together, and must end with `found` high at the same pointer. This shows that the match wins over the limit.

// File: rtl/scan_pkg.sv
package scan_pkg;
    parameter int ADDR_W = 24;
    parameter int NB     = 4;
    parameter int LEN_W  = 16;

    localparam int NEEDLE_W = 8 * NB;
    localparam int SEL_W    = $clog2(NB);
    localparam int CNT_W    = LEN_W + 3;

    typedef enum logic [0:0] {ST_IDLE, ST_RUN} state_t;

    typedef struct packed {
        state_t              state;
        logic                mode;
        logic [SEL_W-1:0]    sel;
        logic [NEEDLE_W-1:0] needle;
        logic [LEN_W-1:0]    maxl;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   rd_ptr;
        logic                pend;
        logic [CNT_W-1:0]    cnt;
        logic [SEL_W-1:0]    ph;
        logic [NEEDLE_W-1:0] win;
        logic                done;
        logic                found;
        logic [ADDR_W-1:0]   result;
    } ctl_t;
endpackage

// File: rtl/scan_match.sv
module scan_match
    import scan_pkg::*;
(
    input  logic [NEEDLE_W-1:0] win,
    input  logic [NEEDLE_W-1:0] needle,
    input  logic [SEL_W-1:0]    sel,
    output logic                hit
);
    logic [NEEDLE_W-1:0] aligned;
    logic [NB-1:0]       lane_ok;

    // place the selected needle bytes at the top, where the newest bytes sit
    assign aligned = needle << (8 * (NB - 1 - int'(sel)));

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_ok[i] = (i < (NB - 1 - int'(sel))) ||
                            (win[8*i +: 8] == aligned[8*i +: 8]);
    end

    assign hit = &lane_ok;
endmodule

// File: rtl/scan_limit.sv
module scan_limit
    import scan_pkg::*;
(
    input  logic             mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] cnt_n,
    input  logic [SEL_W-1:0] ph,
    input  logic [LEN_W-1:0] maxl,
    input  logic             hit,
    output logic             stop_found,
    output logic             stop_end,
    output logic [CNT_W-1:0] cand,
    output logic [CNT_W-1:0] end_off
);
    logic [CNT_W-1:0] w;
    logic [CNT_W-1:0] step;
    logic             eval;
    logic             cond;
    logic             last;

    assign w    = CNT_W'(sel) + CNT_W'(1);
    assign step = mode ? w : CNT_W'(1);
    assign cand = cnt_n - w;

    // scan: every byte once the window is full; skip: at element boundaries
    assign eval = mode ? (ph == sel) : (cnt_n >= w);
    assign cond = mode ? !hit : hit;
    assign last = (cand + step) >= CNT_W'(maxl);

    assign stop_found = eval && cond;
    assign stop_end   = eval && !cond && last;
    assign end_off    = cand + step;
endmodule

// File: rtl/scan_engine.sv
module scan_engine
    import scan_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_LEN_W  = LEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic [P_ADDR_W-1:0] start_ptr,
    input  logic [NEEDLE_W-1:0] needle,
    input  logic [SEL_W-1:0]    needle_sel,
    input  logic [P_LEN_W-1:0]  max_len,
    output logic                done,
    output logic                found,
    output logic [P_ADDR_W-1:0] result_ptr,
    output logic                rd_en,
    output logic [P_ADDR_W-1:0] rd_addr,
    input  logic [7:0]          rd_data
);
    ctl_t c_q, c_d;

    logic [NEEDLE_W-1:0] win_n;
    logic [CNT_W-1:0]    cnt_n;
    logic                hit;
    logic                stop_found;
    logic                stop_end;
    logic [CNT_W-1:0]    cand;
    logic [CNT_W-1:0]    end_off;

    assign win_n = {rd_data, c_q.win[NEEDLE_W-1:8]};
    assign cnt_n = c_q.cnt + CNT_W'(1);

    scan_match u_match (
        .win    (win_n),
        .needle (c_q.needle),
        .sel    (c_q.sel),
        .hit    (hit)
    );

    scan_limit u_limit (
        .mode       (c_q.mode),
        .sel        (c_q.sel),
        .cnt_n      (cnt_n),
        .ph         (c_q.ph),
        .maxl       (c_q.maxl),
        .hit        (hit),
        .stop_found (stop_found),
        .stop_end   (stop_end),
        .cand       (cand),
        .end_off    (end_off)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        rd_en    = 1'b0;
        rd_addr  = c_q.rd_ptr;
        case (c_q.state)
            ST_IDLE: begin
                c_d.pend = 1'b0;
                if (start) begin
                    c_d.mode   = mode;
                    c_d.sel    = needle_sel;
                    c_d.needle = needle;
                    c_d.maxl   = max_len;
                    c_d.base   = start_ptr;
                    c_d.rd_ptr = start_ptr;
                    c_d.cnt    = '0;
                    c_d.ph     = '0;
                    c_d.win    = '0;
                    if (max_len == '0) begin
                        c_d.done   = 1'b1;
                        c_d.found  = 1'b0;
                        c_d.result = start_ptr;
                    end else begin
                        c_d.state = ST_RUN;
                    end
                end
            end
            default: begin
                rd_en      = 1'b1;
                c_d.rd_ptr = c_q.rd_ptr + P_ADDR_W'(1);
                c_d.pend   = 1'b1;
                if (c_q.pend) begin
                    c_d.win = win_n;
                    c_d.cnt = cnt_n;
                    c_d.ph  = (c_q.ph == c_q.sel) ? '0 : c_q.ph + SEL_W'(1);
                    if (stop_found) begin
                        c_d.state  = ST_IDLE;
                        c_d.done   = 1'b1;
                        c_d.found  = 1'b1;
                        c_d.result = c_q.base + P_ADDR_W'(cand);
                    end else if (stop_end) begin
                        c_d.state  = ST_IDLE;
                        c_d.done   = 1'b1;
                        c_d.found  = 1'b0;
                        c_d.result = c_q.base + P_ADDR_W'(end_off);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done       = c_q.done;
    assign found      = c_q.found;
    assign result_ptr = c_q.result;
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk
    import scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_ptr,
    input logic              done,
    input logic              found,
    input logic [ADDR_W-1:0] result_ptr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result_ptr));

    a_r9_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(found));

    a_r8_seq_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    a_r8_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> ($past(start) && rd_addr == $past(start_ptr)));
endmodule

bind scan_engine scan_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_ptr  (start_ptr),
    .done       (done),
    .found      (found),
    .result_ptr (result_ptr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr)
);

// File: tb/scan_engine_test.sv
module scan_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [23:0] start_ptr = '0;
    logic [31:0] needle = '0;
    logic [1:0]  needle_sel = '0;
    logic [15:0] max_len = '0;
    logic        done, found, rd_en;
    logic [23:0] result_ptr, rd_addr;
    logic [7:0]  rd_data;

    logic [7:0] mem [4096];
    int checks = 0;
    int fails  = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[11:0]];
    end

    scan_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .start_ptr(start_ptr), .needle(needle), .needle_sel(needle_sel),
        .max_len(max_len), .done(done), .found(found),
        .result_ptr(result_ptr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [7:0] b);
        mem[addr[11:0]] = b;
    endtask

    task automatic run_op(input logic m, input logic [23:0] sp, input logic [31:0] nd,
                          input logic [1:0] sel, input logic [15:0] ml,
                          output logic f, output logic [23:0] res);
        int n;
        @(negedge clk);
        mode = m; start_ptr = sp; needle = nd; needle_sel = sel; max_len = ml;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 70000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9 no done actual=0 expected=1");
        end
        f = found; res = result_ptr;
        @(negedge clk);
        check("R9 done one cycle", {31'd0, done}, 32'd0);
        check("R9 result held", {8'd0, result_ptr}, {8'd0, res});
    endtask

    task automatic t_reset();
        check("R1 done", {31'd0, done}, 0);
        check("R1 found", {31'd0, found}, 0);
        check("R1 rd_en", {31'd0, rd_en}, 0);
        check("R1 result", {8'd0, result_ptr}, 0);
    endtask

    task automatic t_scan_byte();
        logic f; logic [23:0] r;
        put(12'h100, "H"); put(12'h101, "E"); put(12'h102, "L");
        put(12'h103, "L"); put(12'h104, "O"); put(12'h105, 8'h00);
        run_op(0, 24'h000100, 32'h4C, 0, 100, f, r);
        check("R2 found", {31'd0, f}, 1);
        check("R2 first L", {8'd0, r}, 32'h102);
        run_op(0, 24'h000100, 32'h00, 0, 100, f, r);
        check("R7 strlen", {8'd0, r - 24'h000100}, 5);
    endtask

    task automatic t_multi();
        logic f; logic [23:0] r;
        put(12'h300, 1); put(12'h301, 2); put(12'h302, 3);
        put(12'h303, 1); put(12'h304, 2); put(12'h305, 4);
        run_op(0, 24'h000300, 32'h040201, 2, 100, f, r);
        check("R3 three byte", {8'd0, r}, 32'h303);
        put(12'h310, 1); put(12'h311, 2); put(12'h312, 3); put(12'h313, 5);
        put(12'h314, 1); put(12'h315, 2); put(12'h316, 3); put(12'h317, 4);
        run_op(0, 24'h000310, 32'h04030201, 3, 100, f, r);
        check("R3 four byte", {8'd0, r}, 32'h314);
        check("R3 four byte found", {31'd0, f}, 1);
        put(12'h320, 1); put(12'h321, 2); put(12'h322, 8'h77);
        put(12'h323, 2); put(12'h324, 1);
        run_op(0, 24'h000320, 32'h0102, 1, 100, f, r);
        check("R3 little endian", {8'd0, r}, 32'h323);
    endtask

    task automatic t_skip();
        logic f; logic [23:0] r;
        put(12'h200, 8'h20); put(12'h201, 8'h20); put(12'h202, 8'h20); put(12'h203, 8'h41);
        run_op(1, 24'h000200, 32'h20, 0, 100, f, r);
        check("R4 skip byte", {8'd0, r}, 32'h203);
        check("R4 skip found", {31'd0, f}, 1);
        run_op(1, 24'h000200, 32'h2020, 1, 100, f, r);
        check("R4 skip step two", {8'd0, r}, 32'h202);
        run_op(0, 24'h000200, 32'h4120, 1, 100, f, r);
        check("R3 scan pair", {8'd0, r}, 32'h202);
    endtask

    task automatic t_limit();
        logic f; logic [23:0] r;
        for (int i = 0; i < 8; i++) put(12'h400 + i, 8'h11);
        put(12'h405, 8'h99);
        run_op(0, 24'h000400, 32'h99, 0, 5, f, r);
        check("R5 scan limit found", {31'd0, f}, 0);
        check("R5 scan limit ptr", {8'd0, r}, 32'h405);
        run_op(0, 24'h000400, 32'h99, 0, 6, f, r);
        check("R6 last offset found", {31'd0, f}, 1);
        check("R6 last offset ptr", {8'd0, r}, 32'h405);
        for (int i = 0; i < 12; i++) put(12'h500 + i, 8'h11);
        run_op(1, 24'h000500, 32'h1111, 1, 5, f, r);
        check("R5 skip limit found", {31'd0, f}, 0);
        check("R5 skip limit ptr", {8'd0, r}, 32'h506);
        run_op(0, 24'h000500, 32'h11, 0, 0, f, r);
        check("R5 zero length found", {31'd0, f}, 0);
        check("R5 zero length ptr", {8'd0, r}, 32'h500);
    endtask

    task automatic t_bank();
        logic f; logic [23:0] r;
        put(12'hFFE, 8'h11); put(12'hFFF, 8'h11); put(12'h000, 8'h11); put(12'h001, 8'h5A);
        run_op(0, 24'h01FFFE, 32'h5A, 0, 20, f, r);
        check("R7 bank carry", {8'd0, r}, 32'h020001);
    endtask

    task automatic t_busy_start();
        int n;
        logic [23:0] first_res;
        @(negedge clk);
        mode = 0; start_ptr = 24'h000100; needle = 32'h4F; needle_sel = 0; max_len = 100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R8 read issued", {31'd0, rd_en}, 1);
        check("R8 first addr", {8'd0, rd_addr}, 32'h101);
        start_ptr = 24'h000300; needle = 32'h03; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 1000) begin @(negedge clk); n++; end
        first_res = result_ptr;
        check("R9 start ignored while busy", {8'd0, first_res}, 32'h104);
        repeat (4) @(negedge clk);
        check("R9 no second done", {31'd0, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h11;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan_byte();
        t_multi();
        t_skip();
        t_limit();
        t_bank();
        t_busy_start();
        if (!timed_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule